// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block keeps a 64-bit system time value that timer blocks elsewhere in the chip compare against. Software reaches it through a 32-bit register port that has a write strobe, a shared address and a combinational read-data output. The count advances only on cycles where the input tick qualifier is high and the counter is enabled.

Without scaling, each tick adds one. With scaling, each tick adds an unsigned 8.24 fixed-point increment to a 24-bit fractional accumulator, and the carries out of that accumulator go into the integer count. With an increment of 0x00100000 the count runs at one sixteenth of the tick rate. Software can load either 32-bit half of the count directly, and any such load also clears the fraction. The count is driven out on a port, and a one-cycle pulse marks every cycle in which its value is new.

Top module: `sysctr`

## Requirements
- R1: After reset the control bits are 0, the count is 0, the fraction is 0, status reads 0 and the scale register reads 0x01000000.
- R2: Register offsets: control 0x00 (bit 0 run, bit 2 scale enable, all other bits read 0), status 0x04 (bit 0 mirrors the run bit, read-only, writes have no effect), count low word 0x08, count high word 0x0C, scale 0x10. An unmapped offset reads 0.
- R3: While the run bit is 0, ticks leave the count unchanged.
- R4: While running with scaling off, each cycle with tick high adds exactly 1, and cycles with tick low add nothing.
- R5: While running with scaling on, each tick adds the 8.24 scale value to the 24-bit fraction, and the integer carry is added to the count. 160 ticks at 0x00100000 take the count from 100 to 110.
- R6: A write to the low or high count word replaces only that word at the next clock edge. It takes precedence over a tick in the same cycle.
- R7: Any write to the count clears the fractional accumulator.
- R8: `step_o` is high for exactly the one cycle after each clock edge at which `count_o` changed.
- R9: A carry out of the low word propagates into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count tick qualifier |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| count_o | output | 64 | Current count value |
| step_o | output | 1 | Pulse marking a new count value |

## Verification
The hardest state to reach is a partially filled fractional accumulator at the moment software reloads the count. From the ports, the fraction can only be seen through later carries. The stimulus therefore runs eight ticks at one-sixteenth scale, which leaves the fraction half full. It then rewrites the count and shows that eight further ticks produce no carry, while sixteen do. A second hard case is a count write that lands in the same cycle as a tick. The bench drives both in one cycle to show that the written value wins.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int CNT_W   = 64;
  localparam int DATA_W  = 32;
  localparam int FRAC_W  = 24;
  localparam int SCALE_W = 32;
  localparam int ADDR_W  = 5;
  localparam int INT_W   = SCALE_W - FRAC_W + 1;
  localparam int ACC_W   = INT_W + FRAC_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CLO   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CHI   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_SCALE = 5'h10;

  localparam int BIT_RUN = 0;
  localparam int BIT_SCL = 2;

  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

  typedef struct packed {
    logic [INT_W-1:0]  whole;
    logic [FRAC_W-1:0] frac;
  } acc_t;

  // Adds one scaled increment to the fraction; the whole part is the carry
  function automatic acc_t frac_add(input logic [FRAC_W-1:0] f,
                                    input logic [SCALE_W-1:0] s);
    logic [ACC_W-1:0] sum;
    sum = {{INT_W{1'b0}}, f} + {{(ACC_W-SCALE_W){1'b0}}, s};
    return acc_t'(sum);
  endfunction
endpackage

// File: rtl/sysctr_regfile.sv
module sysctr_regfile
  import sysctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              run_o,
  output logic              scale_on_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic run_q, scl_q;
  logic [SCALE_W-1:0] scale_q;
  logic wr_ctrl, wr_scale, wr_stat;

  assign wr_ctrl  = wr_i && (addr_i == OFS_CTRL);
  assign wr_stat  = wr_i && (addr_i == OFS_STAT);
  assign wr_scale = wr_i && (addr_i == OFS_SCALE);
  assign wr_lo_o  = wr_i && (addr_i == OFS_CLO);
  assign wr_hi_o  = wr_i && (addr_i == OFS_CHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      scl_q   <= 1'b0;
      scale_q <= SCALE_ONE;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata_i[BIT_RUN];
        scl_q <= wdata_i[BIT_SCL];
      end
      if (wr_scale) scale_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_RUN] = run_q;
        rdata_o[BIT_SCL] = scl_q;
      end
      OFS_STAT:  rdata_o[0] = run_q;
      OFS_CLO:   rdata_o = count_i[DATA_W-1:0];
      OFS_CHI:   rdata_o = count_i[CNT_W-1:DATA_W];
      OFS_SCALE: rdata_o = scale_q;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o      = run_q;
  assign scale_on_o = scl_q;
  assign scale_o    = scale_q;

  AST_STAT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ($stable(run_q) && $stable(scl_q) && $stable(scale_q))); // R2
endmodule

// File: rtl/sysctr_core.sv
module sysctr_core
  import sysctr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               scale_on_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               step_o
);
  logic [CNT_W-1:0]  count_q, count_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              step_q;
  acc_t              acc;
  logic              sw_load, advance, adv_plain, adv_scaled;

  assign acc        = frac_add(frac_q, scale_i);
  assign sw_load    = wr_lo_i || wr_hi_i;
  assign advance    = run_i && tick_i && !sw_load;
  assign adv_plain  = advance && !scale_on_i;
  assign adv_scaled = advance && scale_on_i;

  always_comb begin
    count_d = count_q;
    frac_d  = frac_q;
    if (sw_load) begin
      if (wr_lo_i) count_d[DATA_W-1:0]     = wdata_i;
      if (wr_hi_i) count_d[CNT_W-1:DATA_W] = wdata_i;
      frac_d = '0;
    end else if (adv_scaled) begin
      count_d = count_q + CNT_W'(acc.whole);
      frac_d  = acc.frac;
    end else if (adv_plain) begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      frac_q  <= '0;
      step_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      frac_q  <= frac_d;
      step_q  <= (count_d != count_q);
    end
  end

  assign count_o = count_q;
  assign step_o  = step_q;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sw_load) |=> $stable(count_q)); // R3
  AST_PLAIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
    adv_plain |=> (count_q == $past(count_q) + CNT_W'(1))); // R4
  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (count_q[DATA_W-1:0] == $past(wdata_i))); // R6
  AST_FRAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (frac_q == '0)); // R7
  AST_STEP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> step_q); // R8
  AST_STEP_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> (count_q != $past(count_q))); // R8
endmodule

// File: rtl/sysctr.sv
module sysctr
  import sysctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              step_o
);
  logic               run, scale_on, wr_lo, wr_hi;
  logic [SCALE_W-1:0] scale;

  sysctr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .count_i(count_o), .run_o(run),
    .scale_on_o(scale_on), .scale_o(scale), .wr_lo_o(wr_lo),
    .wr_hi_o(wr_hi), .rdata_o(reg_rdata_o)
  );

  sysctr_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .scale_on_i(scale_on), .scale_i(scale), .wr_lo_i(wr_lo),
    .wr_hi_i(wr_hi), .wdata_i(reg_wdata_i), .count_o(count_o),
    .step_o(step_o)
  );

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reg_wr_i) |=> !step_o); // R8
endmodule

// File: tb/tb_sysctr.sv
module tb_sysctr;
  localparam int PERIOD = 10;
  localparam int NVEC = 6;
  // {scale[31:0], ticks[31:0], start[63:0], expected[63:0]}
  localparam logic [191:0] VEC [NVEC] = '{
    {32'h0010_0000, 32'd160, 64'd100, 64'd110},
    {32'h0100_0000, 32'd7,   64'd0,   64'd7},
    {32'h0080_0000, 32'd9,   64'd5,   64'd9},
    {32'h0280_0000, 32'd4,   64'd1000, 64'd1010},
    {32'h0300_0000, 32'd1,   64'h0000_0000_FFFF_FFFE, 64'h0000_0001_0000_0001},
    {32'h0000_0001, 32'd20,  64'd42,  64'd42}
  };

  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] count;
  logic step;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sysctr dut (.clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .count_o(count), .step_o(step));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rreg(5'h00, d); check("R1 ctrl", d, 0);
    rreg(5'h04, d); check("R1 status", d, 0);
    rreg(5'h08, d); check("R1 count lo", d, 0);
    rreg(5'h0C, d); check("R1 count hi", d, 0);
    rreg(5'h10, d); check("R1 scale", d, 32'h0100_0000);
    // R3 disabled holds
    ticks(10);
    check("R3 count held while off", count, 0);
    // R2 ctrl readback masks, status mirror, read-only status, unmapped
    wreg(5'h00, 32'hFFFF_FFFF);
    rreg(5'h00, d); check("R2 ctrl bits", d, 32'h5);
    wreg(5'h00, 32'h1);
    rreg(5'h04, d); check("R2 status run", d, 1);
    wreg(5'h04, 32'h0);
    rreg(5'h00, d); check("R2 status write ignored", d, 1);
    rreg(5'h14, d); check("R2 unmapped", d, 0);
    // R4 plain increment, idle cycles do nothing
    ticks(100);
    check("R4 100 ticks", count, 100);
    repeat (5) @(negedge clk);
    check("R4 no tick no change", count, 100);
    // R8 step pulse
    ticks(1);
    check("R8 step high", step, 1);
    check("R4 one more", count, 101);
    @(negedge clk);
    check("R8 step low", step, 0);
    // R6 write wins over tick in same cycle, other word kept
    wreg(5'h0C, 32'h0000_0007);
    @(negedge clk); wr = 1; addr = 5'h08; wdata = 32'd50; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    check("R6 write beats tick", count, 64'h0000_0007_0000_0032);
    // R7 fraction cleared by count write
    wreg(5'h00, 0);
    wreg(5'h10, 32'h0010_0000);
    wreg(5'h0C, 0);
    wreg(5'h08, 0);
    wreg(5'h00, 32'h5);
    ticks(8);
    wreg(5'h08, 0);
    ticks(8);
    check("R7 fraction cleared", count, 0);
    ticks(8);
    check("R7 carry after 16", count, 1);
    // R3 scale enable alone does not count
    wreg(5'h00, 32'h4);
    ticks(40);
    check("R3 scale without run", count, 1);
    // Vector table: R5 scaled accumulation, R9 word carry
    for (int v = 0; v < NVEC; v++) begin
      wreg(5'h00, 0);
      wreg(5'h08, VEC[v][95:64]);
      wreg(5'h0C, VEC[v][127:96]);
      wreg(5'h10, VEC[v][191:160]);
      wreg(5'h00, 32'h5);
      ticks(int'(VEC[v][159:128]));
      rreg(5'h08, d);
      rreg(5'h0C, hi);
      check("R5 R9 vector count", {hi, d}, VEC[v][63:0]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule